// File: doc/BRIEF.md
# Word Prefetch Read Cache

This block sits on the 16-bit path between main memory and the memory controller. The controller fetches a full 16-bit word for every CPU read but passes only one byte to the CPU. The block keeps the complete word from each fetch, along with its word address and the bank the fetch came from. When a later CPU read asks for either byte of that same word, it raises a hit flag and supplies the byte itself. The surrounding clocking logic can then run a short burst cycle in place of a full bus cycle.

Three read patterns are served from the stored word: a read of the partner byte, a repeat read of the same byte, and a read of the lower byte after the upper one. On a miss, the byte output shows the selected half of the memory word as it arrives. Reads in the top address page, where hardware registers sit, never hit and never load the entry.

A flush input, a CPU write to the cached word, or a change of bank identifier each drop the entry. As a build option, a write can instead update the matching byte.

Top module: `word_prefetch_cache`

## Requirements
- R1: After reset the entry is invalid; the first read never raises `hit`.
- R2: Loading. A read (`cpu_rd`=1) with `mem_valid`=1 outside the top page loads the word. On the next cycle, a read of the other byte of that word in the same bank raises `hit`.
- R3: A repeated read of the same byte address after a load raises `hit`.
- R4: Reading the lower-addressed byte after the upper-addressed byte of a cached word raises `hit`.
- R5: Byte selection. With the default `EVEN_IS_HIGH`=1, an even address returns bits [15:8] and an odd address returns bits [7:0]. The same rule applies to the stored word on a hit and to `mem_data` on a miss.
- R6: An address whose upper 8 bits are all ones never raises `hit` and never loads the entry.
- R7: A `flush` pulse drops the entry, and the following read misses. If a load and a flush happen in the same cycle, the flush wins.
- R8: With the default `WRITE_UPDATES`=0, a write (`cpu_wr`=1) to the cached word drops the entry. A write to any other word leaves the entry intact.
- R9: Any cycle whose `bank_id` differs from the stored bank drops the entry. Returning to the old bank still misses.
- R10: A read of a different word misses. `hit` is 0 whenever `cpu_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte (used only in update mode) |
| bank_id | input | 6 | Current bank identifier |
| mem_data | input | 16 | Word fetched from memory |
| mem_valid | input | 1 | `mem_data` holds a fetched word this cycle |
| flush | input | 1 | Drop the entry |
| hit | output | 1 | Current read is served from the stored word |
| rd_byte | output | 8 | Byte for the CPU |

## Verification
The hardest case to reach is the ordering of entry loss against entry load. Examples are a flush in the same cycle as a fill, a bank change followed by a return to the old bank, and a top-page fetch that falls between a load and its reuse. The bench walks many word addresses through all four access orders. Between those walks it places top-page reads, flushes, writes to matching and non-matching words, and bank switches. A cycle-level reference model in the bench carries the entry across all of them.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  // pick one byte out of a fetched word; even address maps high when hi_even is set
  function automatic logic [7:0] pick_byte(input logic [15:0] w, input logic odd,
                                           input logic hi_even);
    return (odd ^ hi_even) ? w[15:8] : w[7:0];
  endfunction

  // register page detection on the top address byte
  function automatic logic in_reg_page(input logic [7:0] top);
    return &top;
  endfunction

endpackage

// File: rtl/wpc_tag_match.sv
module wpc_tag_match #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 6
) (
  input  logic              valid_q,
  input  logic [ADDR_W-2:0] waddr_q,
  input  logic [BANK_W-1:0] bank_q,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0] bank_id,
  output logic              match,
  output logic              bank_chg
);
  logic waddr_eq, bank_eq;

  assign waddr_eq = (waddr_q == cpu_addr[ADDR_W-1:1]);
  assign bank_eq  = (bank_q == bank_id);
  assign match    = valid_q && waddr_eq && bank_eq;
  assign bank_chg = valid_q && !bank_eq;
endmodule

// File: rtl/wpc_store.sv
module wpc_store #(
  parameter int ADDR_W        = 16,
  parameter int BANK_W        = 6,
  parameter bit EVEN_IS_HIGH  = 1'b1,
  parameter bit WRITE_UPDATES = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fill_evt,
  input  logic              wr_hit,
  input  logic              bank_chg,
  input  logic [15:0]       fill_word,
  input  logic [ADDR_W-2:0] fill_waddr,
  input  logic [BANK_W-1:0] fill_bank,
  input  logic              wr_odd,
  input  logic [7:0]        wr_data,
  output logic              valid_q,
  output logic [15:0]       word_q,
  output logic [ADDR_W-2:0] waddr_q,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      waddr_q <= '0;
      bank_q  <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (fill_evt) begin
      valid_q <= 1'b1;
      word_q  <= fill_word;
      waddr_q <= fill_waddr;
      bank_q  <= fill_bank;
    end else if (wr_hit) begin
      if (WRITE_UPDATES) begin
        if (wr_odd ^ EVEN_IS_HIGH) word_q[15:8] <= wr_data;
        else                       word_q[7:0]  <= wr_data;
      end else begin
        valid_q <= 1'b0;
      end
    end else if (bank_chg) begin
      valid_q <= 1'b0;
    end
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(fill_evt));

  // R8
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_UPDATES && $past(wr_hit && !fill_evt)) |-> !valid_q);
endmodule

// File: rtl/word_prefetch_cache.sv
module word_prefetch_cache #(
  parameter int ADDR_W        = 16,
  parameter int BANK_W        = 6,
  parameter bit EVEN_IS_HIGH  = 1'b1,
  parameter bit WRITE_UPDATES = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  input  logic [BANK_W-1:0] bank_id,
  input  logic [15:0]       mem_data,
  input  logic              mem_valid,
  input  logic              flush,
  output logic              hit,
  output logic [7:0]        rd_byte
);
  import wpc_pkg::*;

  localparam int WADDR_W = ADDR_W - 1;

  logic               reg_page, match, bank_chg, fill_evt, wr_hit;
  logic               valid_q;
  logic [15:0]        word_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [BANK_W-1:0]  bank_q;

  assign reg_page = in_reg_page(cpu_addr[ADDR_W-1 -: 8]);

  wpc_tag_match #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_match (
    .valid_q(valid_q), .waddr_q(waddr_q), .bank_q(bank_q),
    .cpu_addr(cpu_addr), .bank_id(bank_id),
    .match(match), .bank_chg(bank_chg)
  );

  assign hit      = cpu_rd && match && !reg_page;
  assign fill_evt = cpu_rd && mem_valid && !reg_page;
  assign wr_hit   = cpu_wr && match;

  wpc_store #(.ADDR_W(ADDR_W), .BANK_W(BANK_W),
              .EVEN_IS_HIGH(EVEN_IS_HIGH), .WRITE_UPDATES(WRITE_UPDATES)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_evt(fill_evt),
    .wr_hit(wr_hit), .bank_chg(bank_chg), .fill_word(mem_data),
    .fill_waddr(cpu_addr[ADDR_W-1:1]), .fill_bank(bank_id),
    .wr_odd(cpu_addr[0]), .wr_data(cpu_wdata),
    .valid_q(valid_q), .word_q(word_q), .waddr_q(waddr_q), .bank_q(bank_q)
  );

  assign rd_byte = hit ? pick_byte(word_q, cpu_addr[0], EVEN_IS_HIGH)
                       : pick_byte(mem_data, cpu_addr[0], EVEN_IS_HIGH);

  // R7
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

  // R2
  reuse_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_evt && !flush && !cpu_wr) && cpu_rd &&
     cpu_addr[ADDR_W-1:1] == $past(cpu_addr[ADDR_W-1:1]) &&
     bank_id == $past(bank_id)) |-> hit);

  // R5
  reuse_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && $past(fill_evt && !flush && !cpu_wr)) |->
      rd_byte == pick_byte($past(mem_data), cpu_addr[0], EVEN_IS_HIGH));

  // R6
  reg_page_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && mem_valid && reg_page && !cpu_wr) |=> $stable(word_q));
endmodule

// File: tb/word_prefetch_cache_tb.sv
`timescale 1ns/1ps
module word_prefetch_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [5:0]  bank_id = '0;
  logic [15:0] mem_data = '0;
  logic        mem_valid = 1'b0, flush = 1'b0;
  logic        hit;
  logic [7:0]  rd_byte;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference entry
  bit          m_v = 1'b0;
  logic [14:0] m_wa = '0;
  logic [5:0]  m_bk = '0;
  logic [15:0] m_w = '0;

  always #10 clk = ~clk;

  word_prefetch_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .bank_id(bank_id),
    .mem_data(mem_data), .mem_valid(mem_valid), .flush(flush),
    .hit(hit), .rd_byte(rd_byte)
  );

  function automatic logic [7:0] half(input logic [15:0] w, input logic [15:0] a);
    return (a % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  function automatic bit top_page(input logic [15:0] a);
    return a >= 16'hFF00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input logic [15:0] a,
                      input logic [5:0] b, input bit mv, input logic [15:0] md,
                      input bit fl, input string req);
    bit ehit;
    logic [7:0] ebyte;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; bank_id = b;
    mem_valid = mv; mem_data = md; flush = fl; cpu_wdata = 8'h5C;
    #2;
    ehit = rd && m_v && (m_wa == a[15:1]) && (m_bk == b) && !top_page(a);
    ebyte = ehit ? half(m_w, a) : half(md, a);
    check(hit == ehit, req, "hit", int'(hit), int'(ehit));
    if (rd && (ehit || mv))
      check(rd_byte == ebyte, req, "rd_byte", int'(rd_byte), int'(ebyte));
    @(posedge clk);
    if (fl) m_v = 1'b0;
    else if (rd && mv && !top_page(a)) begin
      m_v = 1'b1; m_wa = a[15:1]; m_bk = b; m_w = md;
    end else if (wr && m_v && m_wa == a[15:1] && m_bk == b) m_v = 1'b0;
    else if (m_v && m_bk != b) m_v = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2 check(hit == 1'b0, "R1", "hit after reset", int'(hit), 0);
    step(1, 0, 16'h1234, 6'd0, 0, 16'h0, 0, "R1");

    for (int i = 0; i < 48; i++) begin
      logic [15:0] base = 16'((i << 10) | (i << 1));
      logic [15:0] w = 16'(i * 16'h0107) ^ 16'hA55A;
      if (i % 2 == 0) begin
        step(1, 0, base, 6'd3, 1, w, 0, "R2");
        step(1, 0, base + 1, 6'd3, 0, 16'h0, 0, "R2");
        step(1, 0, base + 1, 6'd3, 0, 16'h0, 0, "R3");
        step(1, 0, base, 6'd3, 0, 16'h0, 0, "R4");
      end else begin
        step(1, 0, base + 1, 6'd3, 1, w, 0, "R5");
        step(1, 0, base + 1, 6'd3, 0, 16'h0, 0, "R3");
        step(1, 0, base, 6'd3, 0, 16'h0, 0, "R4");
        step(1, 0, base + 1, 6'd3, 0, 16'h0, 0, "R5");
      end
      step(0, 0, base, 6'd3, 0, 16'h0, 0, "R10");
      step(1, 0, base + 2, 6'd3, 0, 16'h0, 0, "R10");
    end

    step(1, 0, 16'h0800, 6'd3, 1, 16'hC3E1, 0, "R2");
    for (int p = 0; p < 16; p++) begin
      logic [15:0] ra = 16'hFF00 | 16'(p * 17);
      step(1, 0, ra, 6'd3, 1, 16'(p * 16'h1111), 0, "R6");
      step(1, 0, ra, 6'd3, 0, 16'h0, 0, "R6");
      step(1, 0, 16'h0801, 6'd3, 0, 16'h0, 0, "R6");
    end

    step(1, 0, 16'h2000, 6'd3, 1, 16'h1357, 0, "R2");
    step(0, 0, 16'h2000, 6'd3, 0, 16'h0, 1, "R7");
    step(1, 0, 16'h2001, 6'd3, 0, 16'h0, 0, "R7");
    step(1, 0, 16'h2100, 6'd3, 1, 16'h2468, 1, "R7");
    step(1, 0, 16'h2101, 6'd3, 0, 16'h0, 0, "R7");

    step(1, 0, 16'h3000, 6'd3, 1, 16'h9ABC, 0, "R2");
    step(0, 1, 16'h3002, 6'd3, 0, 16'h0, 0, "R8");
    step(1, 0, 16'h3001, 6'd3, 0, 16'h0, 0, "R8");
    step(0, 1, 16'h3001, 6'd3, 0, 16'h0, 0, "R8");
    step(1, 0, 16'h3000, 6'd3, 0, 16'h0, 0, "R8");

    step(1, 0, 16'h4000, 6'd3, 1, 16'h7E81, 0, "R2");
    step(0, 0, 16'h4000, 6'd5, 0, 16'h0, 0, "R9");
    step(1, 0, 16'h4001, 6'd3, 0, 16'h0, 0, "R9");
    step(1, 0, 16'h4100, 6'd7, 1, 16'h0F0F, 0, "R9");
    step(1, 0, 16'h4101, 6'd7, 0, 16'h0, 0, "R9");
    step(1, 0, 16'h4101, 6'd2, 0, 16'h0, 0, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule